// File: doc/BRIEF.md
# Watchdog and Reset Supervisor Sequencer

This block is the digital core of a processor supervisor. It takes a digitized supply-good flag from an external comparator, a flag that says the system runs on backup power, and a watchdog input that the processor toggles to show it is alive. From these it drives a reset output that is active high, a reset output that is active low, and a watchdog status output. All timeouts are counted in pulses of a clock-enable tick that stands in for a slow timing oscillator. Every timeout length is a parameter.

A reset pulse starts on power-up, while the supply is low or backup power is active, and whenever the watchdog expires. The reset is held for a fixed number of ticks after its cause goes away. The watchdog restarts on every level change of its input. If the input stays at one level for a whole period, the block pulls the watchdog status low and starts a reset pulse. The status stays low until the input changes again. A processor that stays silent therefore gets a reset pulse once per watchdog period. The block has two timing modes. In the uniform mode every watchdog period has the same length. In the alternate mode the first period after each reset is long and the later periods are short.

Top module: `wd_supervisor`

## Requirements
- R1: After the synchronous reset input is released, the reset output stays high for exactly RESET_TICKS ticks and then falls. The watchdog status output is high during that time.
- R2: The reset output goes high on the first clock edge at which the supply-good flag is seen low. It stays high while the flag is low, and it falls RESET_TICKS ticks after the flag returns high.
- R3: While the backup-mode flag is high, the reset output is high and the watchdog status is high. When the flag is cleared, the reset releases RESET_TICKS ticks later.
- R4: The active-low reset output is always the exact complement of the active-high reset output, and both come straight from flip-flops.
- R5: Reset and watchdog timers advance only on clock cycles where the tick input is high. With no ticks, a reset pulse never ends and the watchdog never expires.
- R6: A rising or a falling change of the watchdog input restarts the watchdog period. While changes keep arriving sooner than one period apart, no reset is raised.
- R7: When the watchdog input shows no change for a whole period, the watchdog status falls on the same clock edge at which the reset output rises. That reset pulse lasts RESET_TICKS ticks.
- R8: After a timeout the watchdog status stays low through the end of the reset pulse. It returns high on the clock edge that follows the next change of the watchdog input.
- R9: If the watchdog input stays constant, the reset pulses repeat. Each new pulse begins one full watchdog period after the previous pulse ended.
- R10: While the supply is low, backup mode is active, or the floating flag is high, the watchdog cannot expire and its status is held high. After the floating flag clears, the watchdog counts a full period from zero.
- R11: With the mode select low (uniform mode), every watchdog period is WDT_DEFAULT_TICKS ticks. With the mode select high (alternate mode), the first period after each reset is WDT_LONG_TICKS ticks and each period after an input change is WDT_NORMAL_TICKS ticks.
- R12: The watchdog timer is held at zero while a reset pulse is active. It starts counting on the edge after the reset output falls, so it expires exactly one period of ticks after the reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; acts as the power-up event |
| tick | input | 1 | Clock enable that times all timeouts |
| supply_ok | input | 1 | Digitized supply-above-threshold flag |
| backup_mode | input | 1 | High while running on backup power |
| wdog_in | input | 1 | Watchdog input, already synchronized to clk |
| wdog_float | input | 1 | High when the watchdog input is floating (watchdog disabled) |
| alt_timing | input | 1 | Selects alternate mode (long first period, short later periods) |
| rst_out | output | 1 | Processor reset, active high |
| rst_out_n | output | 1 | Processor reset, active low |
| wdog_n | output | 1 | Watchdog status; low after a timeout until the next input change |

## Verification
A wrong internal state shows up at the ports as a reset pulse whose length or spacing is off by a whole number of ticks. The checks therefore measure the number of clock edges from each cause to the matching reset edge. A period select stuck on the wrong value gives a long-versus-short difference that is visible within one watchdog period. A counter that fails to clear gives a pulse that starts too early on the very next timeout. A status flop that clears at the end of the reset instead of on an input change shows up one edge after that pulse ends. A missing disable shows up as an extra reset within one period of holding the watchdog input still while it floats.

// File: rtl/wds_pkg.sv
package wds_pkg;

  typedef enum logic [1:0] {
    PER_UNIFORM = 2'd0,
    PER_FIRST   = 2'd1,
    PER_SHORT   = 2'd2
  } wdt_period_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wds_edge_detect.sv
module wds_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic change
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_in;
  end

  assign change = level_in ^ level_q;
endmodule

// File: rtl/wds_reset_timer.sv
module wds_reset_timer #(
  parameter int unsigned RESET_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic force_on,
  input  logic trip,
  output logic active_hi,
  output logic active_lo
);
  localparam int unsigned CW = $clog2(RESET_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(RESET_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_d;

  always_comb begin
    act_d = active_hi;
    cnt_d = cnt_q;
    if (force_on || trip) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (active_hi && tick) begin
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      active_hi <= 1'b1;
      active_lo <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      active_hi <= act_d;
      active_lo <= ~act_d;
    end
  end
endmodule

// File: rtl/wds_watchdog.sv
module wds_watchdog
  import wds_pkg::*;
#(
  parameter int unsigned WDT_NORMAL_TICKS  = 100,
  parameter int unsigned WDT_LONG_TICKS    = 1600,
  parameter int unsigned WDT_DEFAULT_TICKS = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic enable,
  input  logic hold,
  input  logic change,
  input  logic alt_mode,
  output logic expire,
  output logic status
);
  localparam int unsigned MAXT = max3(WDT_NORMAL_TICKS, WDT_LONG_TICKS, WDT_DEFAULT_TICKS);
  localparam int unsigned CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          first_q;
  wdt_period_e   sel;

  always_comb begin
    if (!alt_mode)    sel = PER_UNIFORM;
    else if (first_q) sel = PER_FIRST;
    else              sel = PER_SHORT;
    case (sel)
      PER_FIRST: last = CW'(WDT_LONG_TICKS - 1);
      PER_SHORT: last = CW'(WDT_NORMAL_TICKS - 1);
      default:   last = CW'(WDT_DEFAULT_TICKS - 1);
    endcase
  end

  assign expire = enable && !hold && !change && tick && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
      status  <= 1'b1;
    end else if (!enable) begin
      cnt_q  <= '0;
      status <= 1'b1;
    end else begin
      if (change)      status <= 1'b1;
      else if (expire) status <= 1'b0;

      if (hold) begin
        cnt_q   <= '0;
        first_q <= 1'b1;
      end else if (change) begin
        cnt_q   <= '0;
        first_q <= 1'b0;
      end else if (tick) begin
        cnt_q <= expire ? '0 : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wd_supervisor.sv
module wd_supervisor #(
  parameter int unsigned RESET_TICKS       = 200,
  parameter int unsigned WDT_NORMAL_TICKS  = 100,
  parameter int unsigned WDT_LONG_TICKS    = 1600,
  parameter int unsigned WDT_DEFAULT_TICKS = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic supply_ok,
  input  logic backup_mode,
  input  logic wdog_in,
  input  logic wdog_float,
  input  logic alt_timing,
  output logic rst_out,
  output logic rst_out_n,
  output logic wdog_n
);
  logic power_bad;
  logic wd_enable;
  logic in_change;
  logic wd_expire;

  assign power_bad = !supply_ok || backup_mode;
  assign wd_enable = !power_bad && !wdog_float;

  wds_edge_detect u_edge (
    .clk      (clk),
    .rst      (rst),
    .level_in (wdog_in),
    .change   (in_change)
  );

  wds_reset_timer #(
    .RESET_TICKS (RESET_TICKS)
  ) u_rtimer (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .force_on  (power_bad),
    .trip      (wd_expire),
    .active_hi (rst_out),
    .active_lo (rst_out_n)
  );

  wds_watchdog #(
    .WDT_NORMAL_TICKS  (WDT_NORMAL_TICKS),
    .WDT_LONG_TICKS    (WDT_LONG_TICKS),
    .WDT_DEFAULT_TICKS (WDT_DEFAULT_TICKS)
  ) u_wdt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .enable   (wd_enable),
    .hold     (rst_out),
    .change   (in_change),
    .alt_mode (alt_timing),
    .expire   (wd_expire),
    .status   (wdog_n)
  );
endmodule

// File: rtl/wd_supervisor_chk.sv
module wd_supervisor_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic supply_ok,
  input logic backup_mode,
  input logic wdog_in,
  input logic wdog_float,
  input logic rst_out,
  input logic rst_out_n,
  input logic wdog_n
);
  a_r4_complement: assert property (@(posedge clk) disable iff (rst)
    rst_out_n == !rst_out);

  a_r2_supply_low: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> rst_out);

  a_r3_backup: assert property (@(posedge clk) disable iff (rst)
    backup_mode |=> (rst_out && wdog_n));

  a_r10_float_high: assert property (@(posedge clk) disable iff (rst)
    wdog_float |=> wdog_n);

  a_r7_fall_with_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(wdog_n) |-> $rose(rst_out));

  a_r8_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(wdog_n) |-> (($past(wdog_in) != $past(wdog_in, 2)) ||
                       $past(!supply_ok || backup_mode || wdog_float)));

  a_r5_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    (rst_out && !tick) |=> rst_out);
endmodule

bind wd_supervisor wd_supervisor_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .supply_ok   (supply_ok),
  .backup_mode (backup_mode),
  .wdog_in     (wdog_in),
  .wdog_float  (wdog_float),
  .rst_out     (rst_out),
  .rst_out_n   (rst_out_n),
  .wdog_n      (wdog_n)
);

// File: tb/wd_supervisor_test.sv
module wd_supervisor_test;
  localparam int R = 4;
  localparam int N = 6;
  localparam int L = 12;
  localparam int D = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic supply_ok = 1'b1;
  logic backup_mode = 1'b0;
  logic wdog_in = 1'b0;
  logic wdog_float = 1'b0;
  logic alt_timing = 1'b0;
  logic rst_out, rst_out_n, wdog_n;

  int total = 0;
  int bad = 0;
  int n;
  bit flag;

  always #4 clk = ~clk;

  wd_supervisor #(
    .RESET_TICKS(R), .WDT_NORMAL_TICKS(N), .WDT_LONG_TICKS(L), .WDT_DEFAULT_TICKS(D)
  ) uut (
    .clk(clk), .rst(rst), .tick(tick), .supply_ok(supply_ok), .backup_mode(backup_mode),
    .wdog_in(wdog_in), .wdog_float(wdog_float), .alt_timing(alt_timing),
    .rst_out(rst_out), .rst_out_n(rst_out_n), .wdog_n(wdog_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // count negedges until rst_out reaches lvl
  task automatic until_lvl(input logic lvl, output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (rst_out !== lvl && cnt < 300);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state rst_out", int'(rst_out), 1);
    chk("R4 reset state rst_out_n", int'(rst_out_n), 0);
    chk("R1 reset state wdog_n", int'(wdog_n), 1);
    rst = 1'b0;
    until_lvl(1'b0, n);
    chk("R1 power-up pulse length", n, R);
    chk("R4 complement after release", int'(rst_out_n), 1);

    // uniform mode, stuck input
    until_lvl(1'b1, n);
    chk("R11 R12 uniform period", n, D);
    chk("R7 status low at timeout", int'(wdog_n), 0);
    until_lvl(1'b0, n);
    chk("R7 timeout pulse length", n, R);
    chk("R8 status stays low after pulse", int'(wdog_n), 0);
    until_lvl(1'b1, n);
    chk("R9 repeated pulse spacing", n, D);
    until_lvl(1'b0, n);
    chk("R9 repeated pulse length", n, R);

    // rising change restarts period
    repeat (D - 2) @(negedge clk);
    chk("R6 no reset before change", int'(rst_out), 0);
    wdog_in = ~wdog_in;
    @(negedge clk);
    chk("R8 status clears one edge after change", int'(wdog_n), 1);
    until_lvl(1'b1, n);
    chk("R6 rising change restarts period", n, D);
    until_lvl(1'b0, n);

    // falling change restarts period
    repeat (3) @(negedge clk);
    wdog_in = ~wdog_in;
    until_lvl(1'b1, n);
    chk("R6 falling change restarts period", n, D + 1);
    until_lvl(1'b0, n);

    // keep-alive at the tightest spacing
    flag = 1'b1;
    for (int i = 0; i < 8; i++) begin
      repeat (D - 1) @(negedge clk);
      if (rst_out !== 1'b0) flag = 1'b0;
      wdog_in = ~wdog_in;
    end
    @(negedge clk);
    chk("R6 keep-alive holds off reset", int'(flag & !rst_out), 1);
    chk("R8 status high under keep-alive", int'(wdog_n), 1);
    until_lvl(1'b1, n);
    chk("R6 expiry after last change", n, D);
    until_lvl(1'b0, n);

    // floating input disables watchdog
    wdog_float = 1'b1;
    @(negedge clk);
    chk("R10 float forces status high", int'(wdog_n), 1);
    flag = 1'b1;
    repeat (3 * D) begin
      @(negedge clk);
      if (rst_out !== 1'b0 || wdog_n !== 1'b1) flag = 1'b0;
    end
    chk("R10 no expiry while floating", int'(flag), 1);
    wdog_float = 1'b0;
    until_lvl(1'b1, n);
    chk("R10 full period after float clears", n, D);
    until_lvl(1'b0, n);

    // supply drop
    repeat (2) @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    chk("R2 reset on supply low", int'(rst_out), 1);
    chk("R10 status high on supply low", int'(wdog_n), 1);
    flag = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (rst_out !== 1'b1) flag = 1'b0;
    end
    chk("R2 reset held while supply low", int'(flag), 1);
    supply_ok = 1'b1;
    until_lvl(1'b0, n);
    chk("R2 release after supply returns", n, R);
    until_lvl(1'b1, n);
    chk("R12 watchdog fresh after reset", n, D);

    // tick gating
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    tick = 1'b0;
    repeat (30) @(negedge clk);
    chk("R5 reset held without ticks", int'(rst_out), 1);
    tick = 1'b1;
    until_lvl(1'b0, n);
    chk("R5 release after ticks resume", n, R);
    tick = 1'b0;
    flag = 1'b1;
    repeat (3 * D) begin
      @(negedge clk);
      if (rst_out !== 1'b0) flag = 1'b0;
    end
    chk("R5 no watchdog expiry without ticks", int'(flag), 1);
    tick = 1'b1;
    until_lvl(1'b1, n);
    chk("R5 watchdog period after ticks resume", n, D);

    // backup mode
    until_lvl(1'b0, n);
    backup_mode = 1'b1;
    @(negedge clk);
    chk("R3 reset in backup mode", int'(rst_out), 1);
    chk("R3 status high in backup mode", int'(wdog_n), 1);
    chk("R4 complement in backup mode", int'(rst_out_n), 0);
    repeat (10) @(negedge clk);
    backup_mode = 1'b0;
    until_lvl(1'b0, n);
    chk("R3 release after backup ends", n, R);

    // alternate timing mode
    alt_timing = 1'b1;
    until_lvl(1'b1, n);
    chk("R11 alt first period long", n, L);
    until_lvl(1'b0, n);
    until_lvl(1'b1, n);
    chk("R11 alt long again after reset", n, L);
    until_lvl(1'b0, n);
    repeat (3) @(negedge clk);
    wdog_in = ~wdog_in;
    until_lvl(1'b1, n);
    chk("R11 alt short period after change", n, N + 1);
    chk("R7 status low in alt mode", int'(wdog_n), 0);
    until_lvl(1'b0, n);
    chk("R7 pulse length in alt mode", n, R);

    summary();
  end
endmodule